// File: doc/BRIEF.md
# Legacy Level Interrupt Pending Controller

This block sits between the interrupt event sources of one physical function and the link's interrupt signalling. When software leaves legacy mode off, every event pulse is passed on as a message-signalled (MSI-X) request carrying the event's vector, one cycle later. When software turns legacy mode on, message requests stop entirely. The first event then sets a pending flag and raises one of four level-sensitive interrupt lines (INTA to INTD, chosen by a 2-bit field). The line stays high until software writes 1 to the pending-clear field.

Behaviour is held in a three-state machine. `ST_OFF` is legacy mode disabled, with events forwarded. `ST_ARMED` is legacy mode on with nothing pending. `ST_RAISED` is legacy mode on with the pending flag set and the line driven. The transitions are:
- `T_ENABLE` (`ST_OFF`→`ST_ARMED`): a write with the enable field set.
- `T_FIRE` (`ST_ARMED`→`ST_RAISED`): an event while armed.
- `T_ACK` (`ST_RAISED`→`ST_ARMED`): a clear write with no event in the same cycle.
- `T_DISABLE` (`ST_ARMED` or `ST_RAISED` → `ST_OFF`): a write with the enable field clear.

The line-select field sits in a small register of its own. A read port returns the mode, the line select and the pending flag at all times.

Top module: `intx_pend_ctrl`

## Requirements
- R1: After reset, legacy mode is off, the line select is 0, pending is 0, all four lines are low, and no message request is issued.
- R2: With legacy mode off, an event in cycle n gives `msix_valid` high in cycle n+1, with `msix_vector` equal to the event's vector. Back-to-back events give back-to-back requests in order.
- R3: While legacy mode is on, `msix_valid` stays low whatever events arrive.
- R4: With legacy mode on and nothing pending, an event in cycle n sets pending (read bit 3) and raises the selected line in cycle n+1.
- R5: Pending and the line stay high across idle cycles, further events and writes whose bit 3 is 0. A write with bit 3 = 1 and bit 0 = 1 clears both in the next cycle.
- R6: If an event arrives in the same cycle as a clear write, pending and the line stay high.
- R7: Write bits 2:1 choose the line: 0 drives `intx_wire[0]` (INTA), 1 drives bit 1 (INTB), 2 drives bit 2 (INTC), 3 drives bit 3 (INTD). At most one line is ever high.
- R8: With legacy mode off, the pending flag and all lines stay low under any event.
- R9: A write with bit 0 = 0 turns legacy mode off and drops pending and the line in the next cycle. An event in that same cycle is discarded: it is neither forwarded nor held pending.
- R10: After a clear, the next event raises the line again.
- R11: Register write layout: bit 0 is the legacy enable, bits 2:1 are the line select, bit 3 is the pending clear (write 1). Every write updates the enable and the select. The read layout is bit 0 enable, bits 2:1 select, bit 3 pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Interrupt event pulse |
| evt_vector | input | VEC_W | Vector carried by the event |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Write data (layout in R11) |
| reg_rdata | output | 4 | Read data: enable, select, pending |
| intx_wire | output | LINE_N | Level interrupt lines, INTA at bit 0 |
| msix_valid | output | 1 | Message interrupt request |
| msix_vector | output | VEC_W | Vector of the message request |

## Verification
The bench targets the collisions. The first is a clear write in the same cycle as an event: a design that lets the clear win would drop the line while an event is unserviced. The second is a disable write in the same cycle as an event: a wrong design would leak a message request or leave a stale pending bit. It also steps the line select through all four lines, looking for a decoder that drives the wrong or several wires. Finally, it keeps a scoreboard of expected message vectors, so that a request leaking through in legacy mode, a lost request, or a wrong vector shows up as a mismatch.

// File: rtl/intx_pkg.sv
package intx_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_RAISED = 2'd2
    } intx_state_e;

    localparam int REG_W   = 4;
    localparam int EN_BIT  = 0;
    localparam int SEL_LO  = 1;
    localparam int SEL_HI  = 2;
    localparam int CLR_BIT = 3;
endpackage

// File: rtl/intx_sel_reg.sv
module intx_sel_reg
    import intx_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [SEL_W-1:0] sel,
    output logic             en_req,
    output logic             dis_req,
    output logic             clr_req
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
        end else if (reg_we) begin
            sel <= reg_wdata[SEL_LO +: SEL_W];
        end
    end

    always_comb begin
        en_req  = reg_we &&  reg_wdata[EN_BIT];
        dis_req = reg_we && !reg_wdata[EN_BIT];
        clr_req = reg_we &&  reg_wdata[CLR_BIT];
    end
endmodule

// File: rtl/intx_pend_fsm.sv
module intx_pend_fsm
    import intx_pkg::*;
#(
    parameter int LINE_N = 4,
    parameter int SEL_W  = $clog2(LINE_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic              clr_req,
    input  logic [SEL_W-1:0]  sel,
    output logic              legacy_on,
    output logic              pending,
    output logic [LINE_N-1:0] lines
);
    intx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_req) state_d = ST_ARMED;            // T_ENABLE
            end
            ST_ARMED: begin
                if (dis_req)  state_d = ST_OFF;            // T_DISABLE
                else if (evt) state_d = ST_RAISED;         // T_FIRE
            end
            ST_RAISED: begin
                if (dis_req)               state_d = ST_OFF;   // T_DISABLE
                else if (clr_req && !evt)  state_d = ST_ARMED; // T_ACK
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        legacy_on = (state_q != ST_OFF);
        pending   = (state_q == ST_RAISED);
    end

    for (genvar i = 0; i < LINE_N; i++) begin : g_line
        assign lines[i] = pending && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/intx_msi_gate.sv
module intx_msi_gate #(
    parameter int VEC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [VEC_W-1:0] evt_vec,
    input  logic             block,
    output logic             req_valid,
    output logic [VEC_W-1:0] req_vec
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_vec   <= '0;
        end else begin
            req_valid <= evt && !block;
            if (evt && !block) req_vec <= evt_vec;
        end
    end
endmodule

// File: rtl/intx_pend_ctrl.sv
module intx_pend_ctrl
    import intx_pkg::*;
#(
    parameter int VEC_W  = 11,
    parameter int LINE_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [VEC_W-1:0]  evt_vector,
    input  logic              reg_we,
    input  logic [3:0]        reg_wdata,
    output logic [3:0]        reg_rdata,
    output logic [LINE_N-1:0] intx_wire,
    output logic              msix_valid,
    output logic [VEC_W-1:0]  msix_vector
);
    localparam int SEL_W = $clog2(LINE_N);

    logic [SEL_W-1:0] sel;
    logic en_req, dis_req, clr_req, legacy_on, pending;

    intx_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .sel(sel), .en_req(en_req), .dis_req(dis_req), .clr_req(clr_req)
    );

    intx_pend_fsm #(.LINE_N(LINE_N), .SEL_W(SEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .evt(evt_valid), .en_req(en_req),
        .dis_req(dis_req), .clr_req(clr_req), .sel(sel),
        .legacy_on(legacy_on), .pending(pending), .lines(intx_wire)
    );

    intx_msi_gate #(.VEC_W(VEC_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .evt(evt_valid), .evt_vec(evt_vector),
        .block(legacy_on), .req_valid(msix_valid), .req_vec(msix_vector)
    );

    always_comb begin
        reg_rdata                       = '0;
        reg_rdata[EN_BIT]               = legacy_on;
        reg_rdata[SEL_LO +: SEL_W]      = sel;
        reg_rdata[CLR_BIT]              = pending;
    end
endmodule

// File: rtl/intx_pend_ctrl_chk.sv
module intx_pend_ctrl_chk #(
    parameter int VEC_W  = 11,
    parameter int LINE_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [VEC_W-1:0]  evt_vector,
    input logic              reg_we,
    input logic [3:0]        reg_wdata,
    input logic [3:0]        reg_rdata,
    input logic [LINE_N-1:0] intx_wire,
    input logic              msix_valid,
    input logic [VEC_W-1:0]  msix_vector
);
    p_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !reg_rdata[0]) |=> (msix_valid && msix_vector == $past(evt_vector)));

    p_no_msix_legacy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] |=> !msix_valid);

    p_wire_needs_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|intx_wire) |-> reg_rdata[3]);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[3] && !(reg_we && (reg_wdata[3] || !reg_wdata[0]))) |=> reg_rdata[3]);

    p_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[3] && evt_valid && reg_we && reg_wdata[3] && reg_wdata[0]) |=> reg_rdata[3]);

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(intx_wire));

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |-> (intx_wire == '0 && !reg_rdata[3]));

    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && reg_we && !reg_wdata[0]) |=> (!reg_rdata[3] && intx_wire == '0 && !msix_valid));
endmodule

bind intx_pend_ctrl intx_pend_ctrl_chk #(.VEC_W(VEC_W), .LINE_N(LINE_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_vector(evt_vector),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .intx_wire(intx_wire), .msix_valid(msix_valid), .msix_vector(msix_vector)
);

// File: tb/intx_pend_ctrl_test.sv
module intx_pend_ctrl_test;
    localparam int VEC_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evt_valid = 1'b0;
    logic [VEC_W-1:0] evt_vector = '0;
    logic             reg_we = 1'b0;
    logic [3:0]       reg_wdata = '0;
    logic [3:0]       reg_rdata;
    logic [3:0]       intx_wire;
    logic             msix_valid;
    logic [VEC_W-1:0] msix_vector;

    int n_checks = 0;
    int n_fail   = 0;
    bit model_en = 1'b0;
    logic [VEC_W-1:0] exp_q[$];

    always #10 clk = ~clk;

    intx_pend_ctrl #(.VEC_W(VEC_W), .LINE_N(4)) uut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_vector(evt_vector),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .intx_wire(intx_wire), .msix_valid(msix_valid), .msix_vector(msix_vector)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus; pushes expected requests into the scoreboard.
    task automatic cyc(input bit ev, input int vec, input bit we, input int wd);
        @(negedge clk);
        evt_valid  = ev;
        evt_vector = VEC_W'(vec);
        reg_we     = we;
        reg_wdata  = 4'(wd);
        if (ev && !model_en && !(we && 1'b0)) exp_q.push_back(VEC_W'(vec));
        if (we) model_en = wd[0];
        @(negedge clk);
        evt_valid = 1'b0;
        reg_we    = 1'b0;
    endtask

    // Monitor: pops expected requests as the design issues them.
    always @(negedge clk) begin
        if (rst_n && msix_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected request", int'(msix_vector), 0);
            end else begin
                logic [VEC_W-1:0] e;
                e = exp_q.pop_front();
                check(msix_vector == e, "R2 vector", int'(msix_vector), int'(e));
            end
        end
    end

    initial begin
        #3000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rdata == 4'h0, "R1 rdata", reg_rdata, 0);
        check(intx_wire == 4'h0 && !msix_valid, "R1 outputs", {msix_valid, intx_wire}, 0);

        // R2/R8: back-to-back forwarding, mode off
        @(negedge clk);
        evt_valid = 1'b1; evt_vector = 11'd5;   exp_q.push_back(11'd5);
        @(negedge clk);
        evt_vector = 11'h7FF; exp_q.push_back(11'h7FF);
        @(negedge clk);
        evt_vector = 11'd0;   exp_q.push_back(11'd0);
        @(negedge clk);
        evt_valid = 1'b0;
        check(intx_wire == 4'h0 && !reg_rdata[3], "R8 quiet when off", {reg_rdata[3], intx_wire}, 0);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2 all forwarded", exp_q.size(), 0);

        // R11: enable, select INTC
        cyc(0, 0, 1, 4'b0101);
        check(reg_rdata == 4'b0101, "R11 readback", reg_rdata, 4'b0101);

        // R4 + R3
        cyc(1, 9, 0, 0);
        check(reg_rdata[3], "R4 pending", reg_rdata[3], 1);
        check(intx_wire == 4'b0100, "R4 wire", intx_wire, 4'b0100);

        // R5 hold
        cyc(1, 3, 0, 0);
        cyc(0, 0, 1, 4'b0101);
        repeat (3) @(negedge clk);
        check(intx_wire == 4'b0100 && reg_rdata[3], "R5 held", intx_wire, 4'b0100);
        cyc(0, 0, 1, 4'b1101);
        check(intx_wire == 4'b0000 && !reg_rdata[3], "R5 cleared", intx_wire, 0);

        // R10 re-arm, then R6 collision
        cyc(1, 2, 0, 0);
        check(intx_wire == 4'b0100, "R10 re-raised", intx_wire, 4'b0100);
        cyc(1, 2, 1, 4'b1101);
        check(reg_rdata[3] && intx_wire == 4'b0100, "R6 event beats clear", intx_wire, 4'b0100);
        cyc(0, 0, 1, 4'b1101);
        check(!reg_rdata[3], "R6 later clear", reg_rdata[3], 0);

        // R7 sweep
        for (int s = 0; s < 4; s++) begin
            cyc(0, 0, 1, (s << 1) | 1);
            cyc(1, s, 0, 0);
            check(intx_wire == 4'(1 << s), $sformatf("R7 sel %0d", s), intx_wire, 1 << s);
            cyc(0, 0, 1, 4'b1000 | (s << 1) | 1);
            check(intx_wire == 4'h0, "R7 line cleared", intx_wire, 0);
        end

        // R9 disable while pending, event same cycle
        cyc(1, 7, 0, 0);
        check(reg_rdata[3], "R9 setup pending", reg_rdata[3], 1);
        @(negedge clk);
        evt_valid = 1'b1; evt_vector = 11'd42; reg_we = 1'b1; reg_wdata = 4'b0000;
        model_en = 1'b0;
        @(negedge clk);
        evt_valid = 1'b0; reg_we = 1'b0;
        check(reg_rdata == 4'h0 && intx_wire == 4'h0, "R9 dropped", {reg_rdata, intx_wire}, 0);
        check(!msix_valid, "R9 event discarded", msix_valid, 0);

        // R2 again after leaving legacy mode
        cyc(1, 11'h123, 0, 0);
        cyc(1, 11'h456, 0, 0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 resumed forwarding", exp_q.size(), 0);
        check(intx_wire == 4'h0, "R8 off after re-disable", intx_wire, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule